// File: doc/BRIEF.md
# Eight-Sample Integer Lifting Wavelet Transform

This block applies one level of a 5/3-style integer lifting wavelet to a vector of eight unsigned bytes. The vector is cut into four overlapping windows (samples 0 to 2, 2 to 4, 4 to 6 and 6 to 7). A chain of four registered stages processes them in turn. Each stage forms a high-pass (predict) value from its window and a low-pass (update) value that also uses the update value of the stage before it. The first stage has no value from a previous stage. The last stage has only two samples, so its formula is shorter.

A vector enters together with a valid strobe. Its transformed vector leaves with a valid strobe four cycles later. A new vector may be presented on every cycle with no stall. Inside the pipeline, the transform works in place. Lane i of the travelling vector holds input sample i until a stage replaces it with its result. The carried value a stage needs is therefore already sitting in the lane just below its window.

Top module: `lift_dwt_vec`

## Requirements
- R1: `out_valid` is high in exactly those cycles that come four cycles after a cycle in which `in_valid` was high.
- R2: Vectors presented on consecutive cycles are each transformed independently and emerge on consecutive cycles in the same order.
- R3: Sample i is `in_vec[8*i+7 : 8*i]`, and output lane i sits in the same bits of `out_vec`. Output lane 0 is p0 = x1 − ⌊(x0 + x2)/2⌋. Output lane 1 is x0 + ⌊p0/4⌋.
- R4: For the stages starting at sample k = 2 and k = 4, output lane k is p = x(k+1) − ⌊(x(k) + x(k+2))/2⌋. Output lane k+1 is x(k) + ⌊(p + c)/4⌋, where c is output lane k−1.
- R5: For the last stage, output lane 7 is p = x7 − ⌊x6/2⌋. Output lane 6 is x6 + ⌊(p + c)/4⌋, where c is output lane 5. The update and predict lanes are swapped compared with the other stages.
- R6: Each pair sum is formed at 9 bits before a logical right shift. Each subtraction and final addition wraps modulo 256.
- R7: A synchronous active-high reset clears `out_valid` and `out_vec` to zero on the next edge. It also discards every vector still in flight.
- R8: In every cycle where `out_valid` is low, `out_vec` keeps the value it had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A vector is present on `in_vec` |
| in_vec | input | 64 | Eight input samples, sample i in bits 8i+7:8i |
| out_valid | output | 1 | `out_vec` carries a newly finished vector |
| out_vec | output | 64 | Eight transformed lanes, lane i in bits 8i+7:8i |

## Verification
Each stage reads lanes that earlier stages have already overwritten. A stage that picks the wrong carry lane, or writes its two results to swapped lanes, corrupts the lanes of all stages after it. This shows at the output four cycles after the affected vector went in. A valid bit that is lost or duplicated between stages shows as an `out_valid` pulse missing from, or added to, the fourth cycle. A stage register that loads while its valid is low shows as `out_vec` changing in a cycle where `out_valid` is low.

// File: rtl/lift_dwt_pkg.sv
package lift_dwt_pkg;

   typedef enum logic [1:0] {
      KIND_FIRST = 2'd0,
      KIND_MID   = 2'd1,
      KIND_LAST  = 2'd2
   } stage_kind_e;

   function automatic stage_kind_e kind_of(input int idx, input int stages);
      if (idx == 0)
         return KIND_FIRST;
      else if (idx == stages - 1)
         return KIND_LAST;
      else
         return KIND_MID;
   endfunction

endpackage

// File: rtl/lift_dwt_kernel.sv
module lift_dwt_kernel #(
   parameter int W = 8
) (
   input  logic [W-1:0] x0,
   input  logic [W-1:0] x1,
   input  logic [W-1:0] x2,
   input  logic [W-1:0] link,
   output logic [W-1:0] hp,
   output logic [W-1:0] lp
);

   localparam int SW = W + 1;

   logic [SW-1:0] pair_sum;
   logic [SW-1:0] mix_sum;
   logic [W-1:0]  half;
   logic [W-1:0]  quarter;

   // 9-bit sums, logical shifts, results wrap at the data width.
   always_comb begin
      pair_sum = {1'b0, x0} + {1'b0, x2};
      half     = pair_sum[SW-1:1];
      hp       = x1 - half;
      mix_sum  = {1'b0, hp} + {1'b0, link};
      quarter  = {1'b0, mix_sum[SW-1:2]};
      lp       = x0 + quarter;
   end

endmodule

// File: rtl/lift_dwt_stage.sv
module lift_dwt_stage
   import lift_dwt_pkg::*;
#(
   parameter int W      = 8,
   parameter int N      = 8,
   parameter int IDX    = 0,
   parameter int STAGES = N / 2
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           v_in,
   input  logic [N*W-1:0] vec_in,
   output logic           v_out,
   output logic [N*W-1:0] vec_out
);

   localparam stage_kind_e KIND = kind_of(IDX, STAGES);
   localparam int          K    = 2 * IDX;

   logic [W-1:0]   w0, w1, w2, carry;
   logic [W-1:0]   hp, lp;
   logic [N*W-1:0] vec_nxt;

   assign w0 = vec_in[K*W +: W];
   assign w1 = vec_in[(K+1)*W +: W];

   generate
      if (KIND == KIND_FIRST) begin : g_first
         assign carry = '0;
         assign w2    = vec_in[(K+2)*W +: W];
         always_comb begin
            vec_nxt              = vec_in;
            vec_nxt[K*W +: W]     = hp;
            vec_nxt[(K+1)*W +: W] = lp;
         end
      end else if (KIND == KIND_MID) begin : g_mid
         assign carry = vec_in[(K-1)*W +: W];
         assign w2    = vec_in[(K+2)*W +: W];
         always_comb begin
            vec_nxt              = vec_in;
            vec_nxt[K*W +: W]     = hp;
            vec_nxt[(K+1)*W +: W] = lp;
         end
      end else begin : g_last
         // Two-sample window: zero third sample gives x0/2 for the half term.
         assign carry = vec_in[(K-1)*W +: W];
         assign w2    = '0;
         always_comb begin
            vec_nxt              = vec_in;
            vec_nxt[K*W +: W]     = lp;
            vec_nxt[(K+1)*W +: W] = hp;
         end
      end
   endgenerate

   lift_dwt_kernel #(.W(W)) i_kernel (
      .x0   (w0),
      .x1   (w1),
      .x2   (w2),
      .link (carry),
      .hp   (hp),
      .lp   (lp)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         v_out   <= 1'b0;
         vec_out <= '0;
      end else begin
         v_out <= v_in;
         if (v_in)
            vec_out <= vec_nxt;
      end
   end

endmodule

// File: rtl/lift_dwt_vec.sv
module lift_dwt_vec #(
   parameter int W = 8,
   parameter int N = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   input  logic [N*W-1:0] in_vec,
   output logic           out_valid,
   output logic [N*W-1:0] out_vec
);

   localparam int STAGES = N / 2;

   generate
      if (N < 4 || (N % 2) != 0) begin : g_bad_n
         $error("lift_dwt_vec: N must be even and at least 4");
      end
      if (W < 3) begin : g_bad_w
         $error("lift_dwt_vec: W must be at least 3");
      end
   endgenerate

   logic           v_pipe   [STAGES+1];
   logic [N*W-1:0] vec_pipe [STAGES+1];

   assign v_pipe[0]   = in_valid;
   assign vec_pipe[0] = in_vec;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stg
         lift_dwt_stage #(
            .W      (W),
            .N      (N),
            .IDX    (s),
            .STAGES (STAGES)
         ) i_stage (
            .clk     (clk),
            .rst     (rst),
            .v_in    (v_pipe[s]),
            .vec_in  (vec_pipe[s]),
            .v_out   (v_pipe[s+1]),
            .vec_out (vec_pipe[s+1])
         );
      end
   endgenerate

   assign out_valid = v_pipe[STAGES];
   assign out_vec   = vec_pipe[STAGES];

endmodule

// File: rtl/lift_dwt_chk.sv
module lift_dwt_chk #(
   parameter int W = 8,
   parameter int N = 8
) (
   input logic           clk,
   input logic           rst,
   input logic           in_valid,
   input logic [N*W-1:0] in_vec,
   input logic           out_valid,
   input logic [N*W-1:0] out_vec
);

   localparam int STAGES = N / 2;

   logic [STAGES-1:0] vsh;
   logic [N*W-1:0]    dly [STAGES];
   logic [N*W-1:0]    src;

   always_ff @(posedge clk) begin
      if (rst)
         vsh <= '0;
      else
         vsh <= {vsh[STAGES-2:0], in_valid};
      dly[0] <= in_vec;
      for (int i = 1; i < STAGES; i++)
         dly[i] <= dly[i-1];
   end

   assign src = dly[STAGES-1];

   function automatic logic [W-1:0] ln(input logic [N*W-1:0] v, input int i);
      return v[i*W +: W];
   endfunction

   function automatic logic [W-1:0] hi_of(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic [W-1:0] c);
      logic [W:0] t;
      t = {1'b0, a} + {1'b0, c};
      return b - t[W:1];
   endfunction

   function automatic logic [W-1:0] lo_of(input logic [W-1:0] a,
                                          input logic [W-1:0] p,
                                          input logic [W-1:0] c);
      logic [W:0] t;
      t = {1'b0, p} + {1'b0, c};
      return a + {1'b0, t[W:2]};
   endfunction

   // R1
   a_r1_latency: assert property (@(posedge clk) disable iff (rst)
      out_valid == vsh[STAGES-1]);

   // R3
   a_r3_first_stage: assert property (@(posedge clk) disable iff (rst)
      out_valid |->
         (ln(out_vec, 0) == hi_of(ln(src, 0), ln(src, 1), ln(src, 2))) &&
         (ln(out_vec, 1) == lo_of(ln(src, 0), ln(out_vec, 0), '0)));

   // R4
   generate
      for (genvar s = 1; s < STAGES - 1; s++) begin : g_mid_chk
         a_r4_mid_stage: assert property (@(posedge clk) disable iff (rst)
            out_valid |->
               (ln(out_vec, 2*s) ==
                   hi_of(ln(src, 2*s), ln(src, 2*s+1), ln(src, 2*s+2))) &&
               (ln(out_vec, 2*s+1) ==
                   lo_of(ln(src, 2*s), ln(out_vec, 2*s), ln(out_vec, 2*s-1))));
      end
   endgenerate

   // R5
   a_r5_last_stage: assert property (@(posedge clk) disable iff (rst)
      out_valid |->
         (ln(out_vec, N-1) == hi_of(ln(src, N-2), ln(src, N-1), '0)) &&
         (ln(out_vec, N-2) ==
             lo_of(ln(src, N-2), ln(out_vec, N-1), ln(out_vec, N-3))));

   // R7
   a_r7_reset_clears: assert property (@(posedge clk)
      rst |=> (!out_valid && out_vec == '0));

   // R8
   a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && !$past(rst)) |-> $stable(out_vec));

endmodule

bind lift_dwt_vec lift_dwt_chk #(.W(W), .N(N)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_vec    (in_vec),
   .out_valid (out_valid),
   .out_vec   (out_vec)
);

// File: tb/test_lift_dwt_vec.sv
module test_lift_dwt_vec;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] in_vec = '0;
   logic        out_valid;
   logic [63:0] out_vec;

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   string phase  = "reset R7";

   always #5 clk = ~clk;

   lift_dwt_vec #(.W(8), .N(8)) i_lift_dwt_vec (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_vec    (in_vec),
      .out_valid (out_valid),
      .out_vec   (out_vec)
   );

   // Behavioural reference: transform computed with integers.
   function automatic logic [63:0] ref_dwt(input logic [63:0] v);
      int x[8];
      int y[8];
      int p, u, c;
      logic [63:0] r;
      c = 0;
      for (int i = 0; i < 8; i++) x[i] = int'(v[i*8 +: 8]);
      for (int s = 0; s < 4; s++) begin
         int k;
         k = 2 * s;
         if (s == 3) begin
            p = (x[7] - (x[6] >> 1)) & 255;
            u = (x[6] + ((p + c) >> 2)) & 255;
            y[6] = u;
            y[7] = p;
         end else begin
            p = (x[k+1] - ((x[k] + x[k+2]) >> 1)) & 255;
            if (s == 0) u = (x[k] + (p >> 2)) & 255;
            else        u = (x[k] + ((p + c) >> 2)) & 255;
            y[k]   = p;
            y[k+1] = u;
            c      = u;
         end
      end
      for (int i = 0; i < 8; i++) r[i*8 +: 8] = 8'(y[i]);
      return r;
   endfunction

   // Cycle model: four-deep valid/data line, output held between results.
   bit          ev [4];
   logic [63:0] ed [3];
   logic [63:0] eo;

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 4; i++) ev[i] <= 1'b0;
         for (int i = 0; i < 3; i++) ed[i] <= '0;
         eo <= '0;
      end else begin
         ev[0] <= in_valid;
         ed[0] <= ref_dwt(in_vec);
         for (int i = 1; i < 4; i++) ev[i] <= ev[i-1];
         for (int i = 1; i < 3; i++) ed[i] <= ed[i-1];
         if (ev[2]) eo <= ed[2];
      end
   end

   task automatic compare();
      checks++;
      if (out_valid !== ev[3]) begin
         errors++;
         $display("FAIL R1 [%s] out_valid actual %0b expected %0b", phase, out_valid, ev[3]);
      end
      for (int i = 0; i < 8; i++) begin
         string tag;
         if (!ev[3])     tag = "R8";
         else if (i < 2) tag = "R3";
         else if (i < 6) tag = "R4";
         else            tag = "R5";
         checks++;
         if (out_vec[i*8 +: 8] !== eo[i*8 +: 8]) begin
            errors++;
            $display("FAIL %s [%s] lane %0d actual %0d expected %0d",
                     tag, phase, i, out_vec[i*8 +: 8], eo[i*8 +: 8]);
         end
      end
   endtask

   task automatic drive(input bit v, input logic [63:0] d);
      @(negedge clk);
      compare();
      rst      = 1'b0;
      in_valid = v;
      in_vec   = d;
   endtask

   task automatic hold_reset(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
         rst      = 1'b1;
         in_valid = 1'b0;
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      hold_reset(3);
      phase = "idle after reset R7";
      for (int i = 0; i < 3; i++) drive(1'b0, '0);

      phase = "zero vector R3";
      drive(1'b1, '0);
      phase = "ramp R4";
      drive(1'b1, 64'h0807_0605_0403_0201);
      drive(1'b0, '0);
      phase = "all ones wrap R6";
      drive(1'b1, {8{8'hFF}});
      drive(1'b0, '0);
      phase = "alternating wrap R6";
      drive(1'b1, 64'h00FF_00FF_00FF_00FF);
      drive(1'b1, 64'hFF00_FF00_FF00_FF00);
      phase = "falling ramp R5";
      drive(1'b1, 64'h10_30_50_70_90_B0_D0_F0);
      for (int i = 0; i < 6; i++) drive(1'b0, 64'hDEAD_BEEF_0000_1111);

      phase = "back to back R2";
      for (int i = 0; i < 40; i++) drive(1'b1, {$urandom, $urandom});
      phase = "gapped stream R8";
      for (int i = 0; i < 30; i++) drive(i % 3 == 0, {$urandom, $urandom});
      for (int i = 0; i < 6; i++) drive(1'b0, '0);

      phase = "reset mid stream R7";
      for (int i = 0; i < 3; i++) drive(1'b1, {$urandom, $urandom});
      hold_reset(2);
      for (int i = 0; i < 6; i++) drive(1'b0, {$urandom, $urandom});

      phase = "after reset stream R2";
      for (int i = 0; i < 20; i++) drive(1'b1, {$urandom, $urandom});
      for (int i = 0; i < 6; i++) drive(1'b0, '0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected finish");
         summary();
         $finish;
      end
   end

endmodule